// File: doc/BRIEF.md
# Registered Command Buffer with Parity Check

This block is a single register stage on a memory address and command bus. On every rising clock edge it captures up to 25 data bits and drives them onward. A pair of active-low select inputs decides whether the data registers load. When both selects are high the ordinary data outputs hold their last value. The clock-enable and termination-enable bits and the select output are never held, so they follow their inputs every cycle.

Two static configuration inputs choose the output layout. In straight mode all 25 captured bits appear on one flat output. In fan-out mode a 14-bit slice, either the lower or the upper part of the captured word, is driven onto two identical copy outputs. The block also reports the odd parity of the data it captured. A parity input that arrives one clock after its data is compared against that parity, and a registered error flag is raised on a mismatch.

Top module: `cmdbuf_top`

## Requirements
- R1: The data inputs are captured on the rising clock edge, and the captured word appears on the outputs just after that edge.
- R2: When `rst_n` is low at a rising edge, every register clears: all data outputs, `q_cke`, `q_odt`, `q_cs`, `ppo` and `par_err` read 0 after that edge.
- R3: When both `cs0_n` and `cs1_n` are high at an edge, the captured data word does not change, so `q_flat`, `q_a` and `q_b` hold their values.
- R4: When either select input is low at an edge, the data word is loaded from `d_in`.
- R5: `q_cke`, `q_odt` and `q_cs` (the registered `cs0_n`) take their inputs at every edge, whether or not the data is held.
- R6: With `cfg_wide` = 0 (straight mode), `q_flat` carries the captured word and `q_a` and `q_b` read 0.
- R7: With `cfg_wide` = 1 and `cfg_upper` = 0, `q_a` and `q_b` both carry captured bits [13:0] and `q_flat` reads 0.
- R8: With `cfg_wide` = 1 and `cfg_upper` = 1, `q_a` and `q_b` both carry captured bits [24:11].
- R9: In straight mode `cfg_upper` has no effect on any output.
- R10: `ppo` is the XOR of all 25 bits of `d_in` sampled at the last edge. It updates every cycle, even while the data is held.
- R11: `par_err` after edge k+1 equals `par_in` sampled at edge k+1 XOR the `ppo` value from edge k. A 1 means a mismatch.
- R12: The configuration inputs are registered at every edge, so a change shows on the outputs after the next edge, even while the data is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wide | input | 1 | 0 = straight mode, 1 = fan-out mode |
| cfg_upper | input | 1 | Fan-out slice select: 0 = bits [13:0], 1 = bits [24:11] |
| cs0_n | input | 1 | Select input 0, active low |
| cs1_n | input | 1 | Select input 1, active low |
| cke_in | input | 1 | Clock-enable bit, never held |
| odt_in | input | 1 | Termination-enable bit, never held |
| d_in | input | 25 | Data inputs |
| par_in | input | 1 | Parity for the data of the previous edge |
| q_flat | output | 25 | Straight-mode data output |
| q_a | output | 14 | Fan-out copy A |
| q_b | output | 14 | Fan-out copy B |
| q_cke | output | 1 | Registered clock-enable |
| q_odt | output | 1 | Registered termination-enable |
| q_cs | output | 1 | Registered `cs0_n` |
| ppo | output | 1 | Odd parity of the last captured data inputs |
| par_err | output | 1 | Registered parity mismatch flag |

## Verification
Every cycle, the assertions check four things. The data word stays the same when both selects are high and loads when either is low. The control bits track their inputs one edge later. The two fan-out copies always match, and each mode keeps the outputs it does not use at zero. The error flag matches the late parity against the data from two edges before. Only the bench scenarios can show the rest: the clearing done by reset, the choice of slice for each configuration, that `cfg_upper` has no effect in straight mode, and a mode change made while the data is held.

// File: rtl/cmdbuf_pkg.sv
// Package cmdbuf_pkg: shared widths for the registered command buffer.
// Assumes the straight word is at least as wide as the fan-out slice.
package cmdbuf_pkg;
    parameter int unsigned DATA_W = 25;
    parameter int unsigned HALF_W = 14;

    typedef enum logic {
        LAYOUT_STRAIGHT = 1'b0,
        LAYOUT_FANOUT   = 1'b1
    } layout_e;
endpackage

// File: rtl/cmdbuf_capture.sv
// Module cmdbuf_capture: the input register stage.
// The data word loads only when at least one select input is low.
// The control bits and the configuration register load at every edge.
// Assumes synchronous active-low reset and static configuration pins.
module cmdbuf_capture
    import cmdbuf_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wide,
    input  logic         cfg_upper,
    input  logic         cs0_n,
    input  logic         cs1_n,
    input  logic         cke_in,
    input  logic         odt_in,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] data_q,
    output layout_e      layout_q,
    output logic         upper_q,
    output logic         cke_q,
    output logic         odt_q,
    output logic         cs_q
);
    logic deselect;
    assign deselect = cs0_n & cs1_n;

    // Data word: load when selected, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         data_q <= '0;
        else if (!deselect) data_q <= d_in;
    end

    // Control bits and configuration: load at every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            layout_q <= LAYOUT_STRAIGHT;
            upper_q  <= 1'b0;
            cke_q    <= 1'b0;
            odt_q    <= 1'b0;
            cs_q     <= 1'b0;
        end else begin
            layout_q <= layout_e'(cfg_wide);
            upper_q  <= cfg_upper;
            cke_q    <= cke_in;
            odt_q    <= odt_in;
            cs_q     <= cs0_n;
        end
    end

    AST_HOLD_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs0_n && cs1_n) |=> $stable(data_q)); // R3
    AST_LOAD_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs0_n && cs1_n) |=> (data_q == $past(d_in))); // R4
    AST_CTRL_NEVER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cke_q == $past(cke_in) && odt_q == $past(odt_in) && cs_q == $past(cs0_n))); // R5
endmodule

// File: rtl/cmdbuf_fanout.sv
// Module cmdbuf_fanout: lays the captured word out onto the output ports.
// Straight mode drives the whole word flat. Fan-out mode drives one slice
// onto two identical copies. The outputs a mode does not use are held at zero.
module cmdbuf_fanout
    import cmdbuf_pkg::*;
#(
    parameter int unsigned W = DATA_W,
    parameter int unsigned H = HALF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] data_q,
    input  layout_e      layout_q,
    input  logic         upper_q,
    output logic [W-1:0] q_flat,
    output logic [H-1:0] q_a,
    output logic [H-1:0] q_b
);
    localparam int unsigned UPPER_LSB = W - H;

    logic [H-1:0] slice;

    // Slice select: lower or upper H bits of the captured word.
    always_comb begin
        slice = upper_q ? data_q[UPPER_LSB +: H] : data_q[H-1:0];
    end

    // Output layout by mode.
    always_comb begin
        if (layout_q == LAYOUT_FANOUT) begin
            q_flat = '0;
            q_a    = slice;
            q_b    = slice;
        end else begin
            q_flat = data_q;
            q_a    = '0;
            q_b    = '0;
        end
    end

    AST_COPIES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        q_a == q_b); // R7
    AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (layout_q == LAYOUT_FANOUT) ? (q_flat == '0) : (q_a == '0)); // R6
endmodule

// File: rtl/cmdbuf_parity.sv
// Module cmdbuf_parity: the partial-parity output and the late parity check.
// par_in belongs to the data sampled one edge before it, so it is compared
// with the registered parity of that data. Both registers load at every edge.
module cmdbuf_parity
    import cmdbuf_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    input  logic         par_in,
    output logic         ppo_q,
    output logic         err_q
);
    // Parity of the inputs at this edge, and the check for the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ppo_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            ppo_q <= ^d_in;
            err_q <= par_in ^ ppo_q;
        end
    end

    AST_LATE_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (err_q == ($past(par_in) ^ (^$past(d_in, 2))))); // R11
endmodule

// File: rtl/cmdbuf_top.sv
// Module cmdbuf_top: registered command buffer with the selects that hold the data,
// the control bits that pass at every edge, the straight or fan-out layout and the late parity check.
// Assumes a single-ended clock and a synchronous active-low reset.
module cmdbuf_top
    import cmdbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              cfg_upper,
    input  logic              cs0_n,
    input  logic              cs1_n,
    input  logic              cke_in,
    input  logic              odt_in,
    input  logic [DATA_W-1:0] d_in,
    input  logic              par_in,
    output logic [DATA_W-1:0] q_flat,
    output logic [HALF_W-1:0] q_a,
    output logic [HALF_W-1:0] q_b,
    output logic              q_cke,
    output logic              q_odt,
    output logic              q_cs,
    output logic              ppo,
    output logic              par_err
);
    logic [DATA_W-1:0] data_q;
    layout_e           layout_q;
    logic              upper_q;

    cmdbuf_capture #(.W(DATA_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_upper(cfg_upper),
        .cs0_n(cs0_n), .cs1_n(cs1_n), .cke_in(cke_in), .odt_in(odt_in),
        .d_in(d_in), .data_q(data_q), .layout_q(layout_q), .upper_q(upper_q),
        .cke_q(q_cke), .odt_q(q_odt), .cs_q(q_cs)
    );

    cmdbuf_fanout #(.W(DATA_W), .H(HALF_W)) u_fanout (
        .clk(clk), .rst_n(rst_n), .data_q(data_q), .layout_q(layout_q),
        .upper_q(upper_q), .q_flat(q_flat), .q_a(q_a), .q_b(q_b)
    );

    cmdbuf_parity #(.W(DATA_W)) u_parity (
        .clk(clk), .rst_n(rst_n), .d_in(d_in), .par_in(par_in),
        .ppo_q(ppo), .err_q(par_err)
    );
endmodule

// File: tb/cmdbuf_top_bench.sv
// Directed bench for cmdbuf_top: one task for each scenario, checked against a reference model.
module cmdbuf_top_bench;
    import cmdbuf_pkg::*;

    logic clk = 1'b0;
    logic rst_n, cfg_wide, cfg_upper, cs0_n, cs1_n, cke_in, odt_in, par_in;
    logic [DATA_W-1:0] d_in;
    logic [DATA_W-1:0] q_flat;
    logic [HALF_W-1:0] q_a, q_b;
    logic q_cke, q_odt, q_cs, ppo, par_err;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    logic [DATA_W-1:0] m_data;
    logic m_wide, m_upper, m_cke, m_odt, m_cs, m_ppo, m_err;

    cmdbuf_top u_cmdbuf_top (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_upper(cfg_upper),
        .cs0_n(cs0_n), .cs1_n(cs1_n), .cke_in(cke_in), .odt_in(odt_in),
        .d_in(d_in), .par_in(par_in), .q_flat(q_flat), .q_a(q_a), .q_b(q_b),
        .q_cke(q_cke), .q_odt(q_odt), .q_cs(q_cs), .ppo(ppo), .par_err(par_err)
    );

    always #10 clk = ~clk;

    // drive inputs, pass one rising edge, update the model, settle
    task automatic cycle(input logic [DATA_W-1:0] d, input logic c0, input logic c1,
                         input logic ck, input logic od, input logic p);
        d_in = d; cs0_n = c0; cs1_n = c1; cke_in = ck; odt_in = od; par_in = p;
        @(posedge clk);
        if (!rst_n) begin
            m_data = '0; m_wide = 0; m_upper = 0; m_cke = 0; m_odt = 0;
            m_cs = 0; m_ppo = 0; m_err = 0;
        end else begin
            m_wide = cfg_wide; m_upper = cfg_upper;
            if (!(c0 && c1)) m_data = d;
            m_cke = ck; m_odt = od; m_cs = c0;
            m_err = p ^ m_ppo;
            m_ppo = ^d;
        end
        #2;
    endtask

    task automatic check_all(input string tag);
        logic [DATA_W-1:0] e_flat;
        logic [HALF_W-1:0] e_slice;
        e_slice = m_upper ? m_data[DATA_W-1 -: HALF_W] : m_data[HALF_W-1:0];
        e_flat  = m_wide ? '0 : m_data;
        if (!m_wide) e_slice = '0;
        n_checks++;
        if (q_flat !== e_flat || q_a !== e_slice || q_b !== e_slice) begin
            n_fail++;
            $display("FAIL %s data: flat=%h a=%h b=%h expected flat=%h a=b=%h",
                     tag, q_flat, q_a, q_b, e_flat, e_slice);
        end
        n_checks++;
        if ({q_cke, q_odt, q_cs} !== {m_cke, m_odt, m_cs}) begin
            n_fail++;
            $display("FAIL %s ctrl: %b expected %b", tag, {q_cke, q_odt, q_cs}, {m_cke, m_odt, m_cs});
        end
        n_checks++;
        if ({ppo, par_err} !== {m_ppo, m_err}) begin
            n_fail++;
            $display("FAIL %s parity: ppo/err=%b expected %b", tag, {ppo, par_err}, {m_ppo, m_err});
        end
    endtask

    function automatic logic [DATA_W-1:0] rnd();
        return DATA_W'({$urandom, $urandom});
    endfunction

    task automatic t_reset();  // R2
        rst_n = 1'b0;
        cycle('1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        check_all("R2 reset");
        rst_n = 1'b1;
    endtask

    task automatic t_straight();  // R1 R6
        cfg_wide = 0; cfg_upper = 0;
        for (int i = 0; i < 8; i++) begin
            cycle(rnd(), 1'b0, 1'(i[0]), 1'b1, 1'b0, 1'b0);
            check_all("R1 R6 straight capture");
        end
    endtask

    task automatic t_hold();  // R3 R4 R5 R10
        cycle(25'h0AAAAAA, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check_all("R4 load with cs0 low");
        for (int i = 0; i < 4; i++) begin
            cycle(rnd(), 1'b1, 1'b1, 1'(i[0]), 1'(i[1]), 1'b0);
            check_all("R3 R5 R10 held data, controls pass");
        end
        cycle(25'h1555555, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        check_all("R4 load with cs1 low");
    endtask

    task automatic t_fanout();  // R7 R8 R9
        cfg_wide = 1; cfg_upper = 0;
        cycle(25'h1F0C3A5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check_all("R7 fan-out lower slice");
        cfg_upper = 1;
        cycle(25'h1F0C3A5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check_all("R8 fan-out upper slice");
        cfg_wide = 0;
        cycle(25'h0123456, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check_all("R9 straight with upper set");
        cfg_upper = 0;
        cycle(25'h0123456, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check_all("R9 straight with upper clear");
    endtask

    task automatic t_parity();  // R10 R11
        logic [DATA_W-1:0] d;
        for (int i = 0; i < 10; i++) begin
            d = rnd();
            cycle(d, 1'b0, 1'b0, 1'b0, 1'b0, 1'(i % 3 == 0) ^ m_ppo);
            check_all("R10 R11 late parity");
        end
    endtask

    task automatic t_cfg_while_held();  // R12
        cfg_wide = 0;
        cycle(25'h1ABCDEF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cfg_wide = 1; cfg_upper = 1;
        cycle(rnd(), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check_all("R12 mode change while held");
        cfg_wide = 0;
    endtask

    task automatic t_random();  // R1 R3 R5 R11
        for (int i = 0; i < 300; i++) begin
            if (i % 50 == 0) begin cfg_wide = 1'($urandom); cfg_upper = 1'($urandom); end
            cycle(rnd(), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            check_all("R1 R3 R5 R11 random");
        end
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_wide = 0; cfg_upper = 0; cs0_n = 1; cs1_n = 1;
        cke_in = 0; odt_in = 0; par_in = 0; d_in = '0;
        @(negedge clk);
        t_reset();
        t_straight();
        t_hold();
        t_fanout();
        t_parity();
        t_cfg_while_held();
        t_random();
        t_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule